// File: doc/BRIEF.md
# SPI Controller Module Register and Interrupt Unit

This block holds the controller-wide registers of a four-channel SPI master. It also merges the per-channel transfer events into one level-sensitive interrupt line. A 32-bit memory-mapped request port reaches it. The block decodes each access in one of three ways:

- It serves the access locally when the address falls on a module-wide register.
- It forwards the access to one of four external channel slices. The slice is chosen by a fixed address stride.
- It reports the access as unmapped.

Each channel slice raises single-cycle pulses when its transmit side becomes empty or its receive side becomes full. These pulses set sticky bits in an interrupt status register, and software clears those bits by writing ones. A test path can force every interrupt source active and freeze the status register so that software cannot clear it. A soft-reset bit returns all module registers to their reset values and sends a one-cycle reset pulse to the channel slices.

Every access gets a registered response one cycle later. Channel slices see a combinational select, register index, write strobe and read strobe while the request is held.

Top module: `spi_modreg_unit`

## Requirements
- R1: `irq` is high exactly when some bit is set in both the interrupt status register (0x18) and the interrupt enable register (0x1c). It stays low while the enable register is zero.
- R2: The interrupt enable register stores only the bits in mask 0x1777f and reads back zero elsewhere. Status bits outside that mask never become set.
- R3: A pulse on `tx_empty_evt[n]` sets status bit 4n. A pulse on `rx_full_evt[n]` sets status bit 4n+2. The bit is visible one cycle after the pulse and stays set until it is cleared.
- R4: A write to the status register clears each bit written as 1. The write has no effect while module-control bit 3 and system-test bit 11 are both set.
- R5: When an event pulse and a clearing status write hit the same bit in the same cycle, the bit stays set.
- R6: Status is ORed with 0x1777f in either of two cases:
  - a system-test (0x24) write has bit 11 set while module-control bit 3 is set;
  - a module-control (0x28) write has bit 3 set while system-test bit 11 is already set.
  While both bits remain set, the status register reads 0x1777f.
- R7: Address 0x00 reads 0x91 and address 0x14 reads 1. Writes to either address are accepted without error and change nothing.
- R8: A write to 0x10 with bit 1 set resets every module register. The module-control register returns to 4 and the others return to 0. Then 0x10 stores the write data ANDed with 0x31d, and `soft_rst_pulse` is high for one cycle.
- R9: After reset, module control reads 0x4. Module control keeps 4 bits, system test (0x24) keeps 12 bits, wakeup enable (0x20) keeps 1 bit, and system configuration (0x10) keeps the bits of 0x31d.
- R10: Channel n register k sits at byte address 0x2c + 0x14·n + 4·k, with k = 0 config, 1 status, 2 control, 3 TX, 4 RX. An access to that address behaves as follows:
  - `chan_sel` is one-hot at bit n and `chan_reg` = k.
  - A read raises `chan_re` and returns that slice's `chan_rdata` word.
  - A write raises `chan_we`, except for k = 1 and k = 4, which are read-only.
- R11: Any other address, including unaligned addresses, reads zero and ignores writes. Such an access raises `rsp_err` for the one response cycle, and no channel strobe fires.
- R12: Every request cycle produces `rsp_valid` on the following cycle, together with registered `rsp_rdata` and `rsp_err`. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Previous access hit an unmapped address |
| chan_sel | output | NUM_CH | One-hot channel slice select |
| chan_reg | output | 3 | Channel register index |
| chan_we | output | 1 | Write strobe to the selected slice |
| chan_re | output | 1 | Read strobe to the selected slice |
| chan_wdata | output | 32 | Write data to the slices |
| chan_rdata | input | 32·NUM_CH | Read words from the slices, channel n at bits 32n+31:32n |
| tx_empty_evt | input | NUM_CH | Per-channel transmit-empty pulses |
| rx_full_evt | input | NUM_CH | Per-channel receive-full pulses |
| soft_rst_pulse | output | 1 | One-cycle reset to the channel slices |
| irq | output | 1 | Level interrupt |

## Verification
Register responses, status updates from event pulses and the `irq` level all change on the first clock edge after the stimulus. The soft-reset pulse also appears one edge after the configuration write. The channel select and strobes are combinational and valid while the request is held. The bench applies stimulus on a falling edge. It probes the channel strobes a moment later in that same cycle, and it reads responses, `irq` and `soft_rst_pulse` on the next falling edge, so each value is sampled half a cycle after the edge that produced it. Expected read data is queued when the request is issued and popped as each response arrives, so a response that arrives a cycle late or early fails its comparison.

// File: rtl/spi_modreg_pkg.sv
package spi_modreg_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int IRQ_W      = 17;
    localparam int MAX_CH     = 4;
    localparam int CH_IDX_W   = 2;
    localparam int CH_REGS    = 5;
    localparam int CH_BASE    = 'h2c;
    localparam int CH_STRIDE  = 'h14;

    localparam logic [IRQ_W-1:0]  IRQ_MASK    = 17'h1777f;
    localparam logic [DATA_W-1:0] REV_VALUE   = 32'h0000_0091;
    localparam logic [DATA_W-1:0] SYSCFG_MASK = 32'h0000_031d;

    localparam int SYST_W        = 12;
    localparam int MODCTL_W      = 4;
    localparam logic [MODCTL_W-1:0] MODCTL_RST = 4'h4;
    localparam int SYST_FORCE_B  = 11;
    localparam int MODCTL_TEST_B = 3;
    localparam int SYSCFG_SRST_B = 1;

    localparam logic [ADDR_W-1:0] A_REV     = 8'h00;
    localparam logic [ADDR_W-1:0] A_SYSCFG  = 8'h10;
    localparam logic [ADDR_W-1:0] A_SYSSTAT = 8'h14;
    localparam logic [ADDR_W-1:0] A_IRQST   = 8'h18;
    localparam logic [ADDR_W-1:0] A_IRQEN   = 8'h1c;
    localparam logic [ADDR_W-1:0] A_WAKE    = 8'h20;
    localparam logic [ADDR_W-1:0] A_SYST    = 8'h24;
    localparam logic [ADDR_W-1:0] A_MODCTL  = 8'h28;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_REV,
        RK_SYSCFG,
        RK_SYSSTAT,
        RK_IRQST,
        RK_IRQEN,
        RK_WAKE,
        RK_SYST,
        RK_MODCTL,
        RK_CHAN
    } reg_kind_e;

    typedef enum logic [2:0] {
        CR_CONF = 3'd0,
        CR_STAT = 3'd1,
        CR_CTRL = 3'd2,
        CR_TX   = 3'd3,
        CR_RX   = 3'd4
    } chan_reg_e;

    typedef struct packed {
        reg_kind_e             kind;
        logic [CH_IDX_W-1:0]   ch;
        chan_reg_e             creg;
    } dec_t;

    function automatic logic chan_reg_writable(chan_reg_e r);
        return !(r == CR_STAT || r == CR_RX);
    endfunction

endpackage

// File: rtl/spi_modreg_decode.sv
module spi_modreg_decode
    import spi_modreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.kind = RK_NONE;
        dec.ch   = '0;
        dec.creg = CR_CONF;
        if (addr[1:0] == 2'b00) begin
            unique case (addr)
                A_REV:     dec.kind = RK_REV;
                A_SYSCFG:  dec.kind = RK_SYSCFG;
                A_SYSSTAT: dec.kind = RK_SYSSTAT;
                A_IRQST:   dec.kind = RK_IRQST;
                A_IRQEN:   dec.kind = RK_IRQEN;
                A_WAKE:    dec.kind = RK_WAKE;
                A_SYST:    dec.kind = RK_SYST;
                A_MODCTL:  dec.kind = RK_MODCTL;
                default: begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        for (int k = 0; k < CH_REGS; k++) begin
                            if (addr == ADDR_W'(CH_BASE + i * CH_STRIDE + 4 * k)) begin
                                dec.kind = RK_CHAN;
                                dec.ch   = CH_IDX_W'(i);
                                dec.creg = chan_reg_e'(k[2:0]);
                            end
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_modreg_cfg.sv
module spi_modreg_cfg
    import spi_modreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  reg_kind_e           kind,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   syscfg_q,
    output logic                wake_q,
    output logic [SYST_W-1:0]   syst_q,
    output logic [MODCTL_W-1:0] modctl_q,
    output logic                soft_rst,
    output logic                force_set,
    output logic                clr_lock
);

    logic wr_syscfg, wr_syst, wr_modctl;

    assign wr_syscfg = wr && (kind == RK_SYSCFG);
    assign wr_syst   = wr && (kind == RK_SYST);
    assign wr_modctl = wr && (kind == RK_MODCTL);

    assign soft_rst  = wr_syscfg && wdata[SYSCFG_SRST_B];
    assign clr_lock  = modctl_q[MODCTL_TEST_B] && syst_q[SYST_FORCE_B];
    assign force_set = (wr_syst && modctl_q[MODCTL_TEST_B] && wdata[SYST_FORCE_B])
                    || (wr_modctl && wdata[MODCTL_TEST_B] && syst_q[SYST_FORCE_B]);

    always_ff @(posedge clk) begin
        if (rst) begin
            syscfg_q <= '0;
            wake_q   <= 1'b0;
            syst_q   <= '0;
            modctl_q <= MODCTL_RST;
        end else if (soft_rst) begin
            syscfg_q <= wdata & SYSCFG_MASK;
            wake_q   <= 1'b0;
            syst_q   <= '0;
            modctl_q <= MODCTL_RST;
        end else begin
            if (wr_syscfg)
                syscfg_q <= wdata & SYSCFG_MASK;
            if (wr && kind == RK_WAKE)
                wake_q <= wdata[0];
            if (wr_syst)
                syst_q <= wdata[SYST_W-1:0];
            if (wr_modctl)
                modctl_q <= wdata[MODCTL_W-1:0];
        end
    end

endmodule

// File: rtl/spi_modreg_irq.sv
module spi_modreg_irq
    import spi_modreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              st_wr,
    input  logic              en_wr,
    input  logic [IRQ_W-1:0]  wdata,
    input  logic              clr_lock,
    input  logic              force_set,
    input  logic [NUM_CH-1:0] tx_evt,
    input  logic [NUM_CH-1:0] rx_evt,
    output logic [IRQ_W-1:0]  status_q,
    output logic [IRQ_W-1:0]  enable_q,
    output logic              irq
);

    logic [IRQ_W-1:0] evt_bits;
    logic [IRQ_W-1:0] status_d;

    for (genvar b = 0; b < IRQ_W; b++) begin : g_evt
        if ((b % 4 == 0) && (b / 4 < NUM_CH)) begin : g_tx
            assign evt_bits[b] = tx_evt[b/4];
        end else if ((b % 4 == 2) && (b / 4 < NUM_CH)) begin : g_rx
            assign evt_bits[b] = rx_evt[b/4];
        end else begin : g_zero
            assign evt_bits[b] = 1'b0;
        end
    end

    always_comb begin
        status_d = status_q;
        if (soft_rst)
            status_d = '0;
        else if (force_set)
            status_d = status_q | IRQ_MASK;
        else if (st_wr && !clr_lock)
            status_d = status_q & ~wdata;
        status_d = status_d | evt_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            if (soft_rst)
                enable_q <= '0;
            else if (en_wr)
                enable_q <= wdata & IRQ_MASK;
        end
    end

    assign irq = |(status_q & enable_q);

endmodule

// File: rtl/spi_modreg_unit.sv
module spi_modreg_unit
    import spi_modreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [7:0]               req_addr,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    output logic                     rsp_err,
    output logic [NUM_CH-1:0]        chan_sel,
    output logic [2:0]               chan_reg,
    output logic                     chan_we,
    output logic                     chan_re,
    output logic [31:0]              chan_wdata,
    input  logic [NUM_CH*32-1:0]     chan_rdata,
    input  logic [NUM_CH-1:0]        tx_empty_evt,
    input  logic [NUM_CH-1:0]        rx_full_evt,
    output logic                     soft_rst_pulse,
    output logic                     irq
);

    dec_t dec;
    logic                wr;
    logic [DATA_W-1:0]   syscfg_w;
    logic                wake_w;
    logic [SYST_W-1:0]   syst_w;
    logic [MODCTL_W-1:0] modctl_w;
    logic                soft_rst_w, force_w, lock_w;
    logic [IRQ_W-1:0]    status_w, enable_w;
    logic [DATA_W-1:0]   rd_word;
    logic [DATA_W-1:0]   chan_word;
    logic                chan_hit;

    spi_modreg_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    assign wr       = req_valid && req_write;
    assign chan_hit = req_valid && (dec.kind == RK_CHAN);

    spi_modreg_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .kind      (dec.kind),
        .wdata     (req_wdata),
        .syscfg_q  (syscfg_w),
        .wake_q    (wake_w),
        .syst_q    (syst_w),
        .modctl_q  (modctl_w),
        .soft_rst  (soft_rst_w),
        .force_set (force_w),
        .clr_lock  (lock_w)
    );

    spi_modreg_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst_w),
        .st_wr     (wr && dec.kind == RK_IRQST),
        .en_wr     (wr && dec.kind == RK_IRQEN),
        .wdata     (req_wdata[IRQ_W-1:0]),
        .clr_lock  (lock_w),
        .force_set (force_w),
        .tx_evt    (tx_empty_evt),
        .rx_evt    (rx_full_evt),
        .status_q  (status_w),
        .enable_q  (enable_w),
        .irq       (irq)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        assign chan_sel[c] = chan_hit && (dec.ch == CH_IDX_W'(c));
    end

    assign chan_reg   = dec.creg;
    assign chan_we    = chan_hit && req_write && chan_reg_writable(dec.creg);
    assign chan_re    = chan_hit && !req_write;
    assign chan_wdata = req_wdata;

    always_comb begin
        chan_word = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (chan_sel[i])
                chan_word = chan_rdata[i*DATA_W +: DATA_W];
    end

    always_comb begin
        unique case (dec.kind)
            RK_REV:     rd_word = REV_VALUE;
            RK_SYSCFG:  rd_word = syscfg_w;
            RK_SYSSTAT: rd_word = 32'd1;
            RK_IRQST:   rd_word = DATA_W'(status_w);
            RK_IRQEN:   rd_word = DATA_W'(enable_w);
            RK_WAKE:    rd_word = DATA_W'(wake_w);
            RK_SYST:    rd_word = DATA_W'(syst_w);
            RK_MODCTL:  rd_word = DATA_W'(modctl_w);
            RK_CHAN:    rd_word = chan_word;
            default:    rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
            rsp_err        <= 1'b0;
            soft_rst_pulse <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_err        <= req_valid && (dec.kind == RK_NONE);
            rsp_rdata      <= (req_valid && !req_write) ? rd_word : '0;
            soft_rst_pulse <= soft_rst_w;
        end
    end

endmodule

// File: rtl/spi_modreg_chk.sv
module spi_modreg_chk
    import spi_modreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [NUM_CH-1:0]   tx_evt,
    input logic [NUM_CH-1:0]   rx_evt,
    input logic [IRQ_W-1:0]    status,
    input logic [IRQ_W-1:0]    enable,
    input logic [SYST_W-1:0]   syst,
    input logic [MODCTL_W-1:0] modctl,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic [31:0]         rsp_rdata,
    input logic [NUM_CH-1:0]   chan_sel,
    input logic                soft_rst_pulse,
    input logic                irq
);

    p_irq_off_r1: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq);

    p_enable_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (enable & ~IRQ_MASK) == '0);

    p_status_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (status & ~IRQ_MASK) == '0);

    p_tx_evt_r3: assert property (@(posedge clk) disable iff (rst)
        tx_evt[0] |=> status[0]);

    p_rx_evt_r3: assert property (@(posedge clk) disable iff (rst)
        rx_evt[0] |=> status[2]);

    p_lock_full_r6: assert property (@(posedge clk) disable iff (rst)
        (modctl[MODCTL_TEST_B] && syst[SYST_FORCE_B]) |-> (status == IRQ_MASK));

    p_softrst_regs_r8: assert property (@(posedge clk) disable iff (rst)
        soft_rst_pulse |-> (modctl == MODCTL_RST && enable == '0 && syst == '0));

    p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_sel));

    p_err_zero_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    p_rsp_follow_r12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_rsp_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

endmodule

bind spi_modreg_unit spi_modreg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .tx_evt         (tx_empty_evt),
    .rx_evt         (rx_full_evt),
    .status         (status_w),
    .enable         (enable_w),
    .syst           (syst_w),
    .modctl         (modctl_w),
    .rsp_valid      (rsp_valid),
    .rsp_err        (rsp_err),
    .rsp_rdata      (rsp_rdata),
    .chan_sel       (chan_sel),
    .soft_rst_pulse (soft_rst_pulse),
    .irq            (irq)
);

// File: tb/spi_modreg_unit_bench.sv
`timescale 1ns/100ps
module spi_modreg_unit_bench;

    localparam int NCH = 4;
    localparam logic [31:0] MASK = 32'h0001_777f;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, rsp_err, chan_we, chan_re, soft_rst_pulse, irq;
    logic [31:0] rsp_rdata, chan_wdata;
    logic [NCH-1:0] chan_sel;
    logic [2:0] chan_reg;
    logic [NCH*32-1:0] chan_rdata;
    logic [NCH-1:0] tx_empty_evt = '0, rx_full_evt = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] d;
        logic        e;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    always #2.5 clk = ~clk;

    for (genvar i = 0; i < NCH; i++) begin : g_slice
        assign chan_rdata[i*32 +: 32] = 32'hC0DE_0000 + i;
    end

    spi_modreg_unit #(.NUM_CH(NCH)) u_spi_modreg_unit (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .chan_sel(chan_sel), .chan_reg(chan_reg),
        .chan_we(chan_we), .chan_re(chan_re), .chan_wdata(chan_wdata),
        .chan_rdata(chan_rdata),
        .tx_empty_evt(tx_empty_evt), .rx_full_evt(rx_full_evt),
        .soft_rst_pulse(soft_rst_pulse), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: one response per queued expectation
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected response", 32'd1, 32'd0);
            end else begin
                cur = exp_q.pop_front();
                check(cur.tag, rsp_rdata, cur.d);
                check({cur.tag, " err"}, {31'b0, rsp_err}, {31'b0, cur.e});
            end
        end
    end

    // driver: one access, optionally with event pulses and a strobe probe
    task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] exp, input logic experr, input string tag,
                       input logic [3:0] tx = '0, input logic [3:0] rx = '0,
                       input bit probe = 0, input logic [3:0] esel = '0,
                       input logic [2:0] ereg = '0, input logic ewe = 0,
                       input logic ere = 0);
        exp_t it;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        tx_empty_evt = tx; rx_full_evt = rx;
        it.d = wr ? 32'd0 : exp; it.e = experr; it.tag = tag;
        exp_q.push_back(it);
        if (probe) begin
            #1;
            check({tag, " sel"}, {28'b0, chan_sel}, {28'b0, esel});
            if (esel != 0)
                check({tag, " reg"}, {29'b0, chan_reg}, {29'b0, ereg});
            check({tag, " we"}, {31'b0, chan_we}, {31'b0, ewe});
            check({tag, " re"}, {31'b0, chan_re}, {31'b0, ere});
        end
        @(negedge clk);
        req_valid = 1'b0; tx_empty_evt = '0; rx_full_evt = '0;
    endtask

    task automatic pulse(input logic [3:0] tx, input logic [3:0] rx);
        @(negedge clk);
        tx_empty_evt = tx; rx_full_evt = rx;
        @(negedge clk);
        tx_empty_evt = '0; rx_full_evt = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {31'b0, irq}, 32'd0);

        // reset values and fixed reads
        acc(0, 8'h00, 0, 32'h91, 0, "R7 revision");
        acc(0, 8'h14, 0, 32'h1, 0, "R7 sysstatus");
        acc(0, 8'h28, 0, 32'h4, 0, "R9 modctl reset");
        acc(0, 8'h1c, 0, 32'h0, 0, "R9 enable reset");
        acc(0, 8'h18, 0, 32'h0, 0, "R9 status reset");
        acc(0, 8'h24, 0, 32'h0, 0, "R9 systest reset");
        acc(1, 8'h00, 32'hFFFF, 0, 0, "R7 write revision");
        acc(1, 8'h14, 32'h5, 0, 0, "R7 write sysstatus");
        acc(0, 8'h00, 0, 32'h91, 0, "R7 revision unchanged");
        acc(0, 8'h14, 0, 32'h1, 0, "R7 sysstatus unchanged");

        // R2 enable mask
        acc(1, 8'h1c, 32'hFFFF_FFFF, 0, 0, "R2 enable write");
        acc(0, 8'h1c, 0, MASK, 0, "R2 enable masked");
        check("R1 irq no status", {31'b0, irq}, 32'd0);

        // R3 events
        pulse(4'b0010, 4'b0000);
        check("R1 irq after tx ch1", {31'b0, irq}, 32'd1);
        acc(0, 8'h18, 0, 32'h10, 0, "R3 tx ch1 bit4");
        pulse(4'b0000, 4'b1000);
        acc(0, 8'h18, 0, 32'h4010, 0, "R3 rx ch3 bit14");
        pulse(4'b0001, 4'b0100);
        acc(0, 8'h18, 0, 32'h4411, 0, "R3 tx ch0 rx ch2");

        // R4 write-one-to-clear
        acc(1, 8'h18, 32'h4010, 0, 0, "R4 clear some");
        acc(0, 8'h18, 0, 32'h401, 0, "R4 partial clear");
        acc(1, 8'h18, 32'hFFFF_FFFF, 0, 0, "R4 clear all");
        acc(0, 8'h18, 0, 32'h0, 0, "R4 all cleared");
        check("R1 irq cleared", {31'b0, irq}, 32'd0);

        // R1 enable selects sources
        acc(1, 8'h1c, 32'h4, 0, 0, "R1 enable bit2");
        pulse(4'b0001, 4'b0000);
        check("R1 irq masked source", {31'b0, irq}, 32'd0);
        pulse(4'b0000, 4'b0001);
        check("R1 irq enabled source", {31'b0, irq}, 32'd1);

        // R5 event beats clear
        acc(1, 8'h18, 32'h4, 0, 0, "R5 clear with event", 4'b0000, 4'b0001);
        acc(0, 8'h18, 0, 32'h5, 0, "R5 event kept");
        check("R5 irq kept", {31'b0, irq}, 32'd1);
        acc(1, 8'h18, 32'h5, 0, 0, "R4 clear rest");
        check("R1 irq low again", {31'b0, irq}, 32'd0);

        // R6 force paths and R4 lock
        acc(1, 8'h28, 32'h8, 0, 0, "R6 test mode on");
        acc(0, 8'h18, 0, 32'h0, 0, "R6 no force without bit11");
        acc(1, 8'h24, 32'hFFFF_F800, 0, 0, "R6 systest force");
        acc(0, 8'h18, 0, MASK, 0, "R6 forced by systest");
        acc(0, 8'h24, 0, 32'h800, 0, "R9 systest 12 bits");
        acc(1, 8'h18, 32'hFFFF_FFFF, 0, 0, "R4 locked clear");
        acc(0, 8'h18, 0, MASK, 0, "R4 clear ignored");
        check("R1 irq forced", {31'b0, irq}, 32'd1);
        acc(1, 8'h28, 32'h0, 0, 0, "R6 test mode off");
        acc(1, 8'h18, 32'hFFFF_FFFF, 0, 0, "R4 unlocked clear");
        acc(0, 8'h18, 0, 32'h0, 0, "R4 clear works again");
        acc(1, 8'h28, 32'hFF, 0, 0, "R6 modctl force");
        acc(0, 8'h18, 0, MASK, 0, "R6 forced by modctl");
        acc(0, 8'h28, 0, 32'hF, 0, "R9 modctl 4 bits");

        // R9 wakeup width
        acc(1, 8'h20, 32'hFFFF_FFFF, 0, 0, "R9 wake write");
        acc(0, 8'h20, 0, 32'h1, 0, "R9 wake 1 bit");

        // R8 soft reset
        acc(1, 8'h10, 32'hFFFF_FFFF, 0, 0, "R8 soft reset write");
        check("R8 soft reset pulse", {31'b0, soft_rst_pulse}, 32'd1);
        acc(0, 8'h10, 0, 32'h31d, 0, "R8 syscfg masked");
        check("R8 pulse one cycle", {31'b0, soft_rst_pulse}, 32'd0);
        acc(0, 8'h28, 0, 32'h4, 0, "R8 modctl reset");
        acc(0, 8'h1c, 0, 32'h0, 0, "R8 enable reset");
        acc(0, 8'h18, 0, 32'h0, 0, "R8 status reset");
        acc(0, 8'h24, 0, 32'h0, 0, "R8 systest reset");
        acc(0, 8'h20, 0, 32'h0, 0, "R8 wake reset");
        check("R8 irq low", {31'b0, irq}, 32'd0);
        acc(1, 8'h10, 32'h1C, 0, 0, "R9 syscfg plain write");
        check("R8 no pulse without bit1", {31'b0, soft_rst_pulse}, 32'd0);
        acc(0, 8'h10, 0, 32'h1C, 0, "R9 syscfg stored");

        // R10 channel routing
        acc(1, 8'h60, 32'h1234, 0, 0, "R10 ch2 tx write", '0, '0, 1, 4'b0100, 3'd3, 1, 0);
        acc(0, 8'h78, 0, 32'hC0DE_0003, 0, "R10 ch3 rx read", '0, '0, 1, 4'b1000, 3'd4, 0, 1);
        acc(1, 8'h44, 32'h1, 0, 0, "R10 ch1 status write", '0, '0, 1, 4'b0010, 3'd1, 0, 0);
        acc(0, 8'h2c, 0, 32'hC0DE_0000, 0, "R10 ch0 config read", '0, '0, 1, 4'b0001, 3'd0, 0, 1);
        acc(0, 8'h54, 0, 32'hC0DE_0002, 0, "R10 ch2 config read", '0, '0, 1, 4'b0100, 3'd0, 0, 1);
        acc(1, 8'h34, 32'h1, 0, 0, "R10 ch0 control write", '0, '0, 1, 4'b0001, 3'd2, 1, 0);

        // R11 unmapped
        acc(0, 8'h04, 0, 32'h0, 1, "R11 read 0x04", '0, '0, 1, 4'b0000, 3'd0, 0, 0);
        acc(0, 8'h7c, 0, 32'h0, 1, "R11 read past channels", '0, '0, 1, 4'b0000, 3'd0, 0, 0);
        acc(0, 8'h2e, 0, 32'h0, 1, "R11 unaligned read", '0, '0, 1, 4'b0000, 3'd0, 0, 0);
        acc(1, 8'h0c, 32'hFFFF_FFFF, 0, 1, "R11 write 0x0c");
        acc(0, 8'hFC, 0, 32'h0, 1, "R11 read 0xfc");
        acc(0, 8'h1c, 0, 32'h0, 0, "R11 no side effect");

        repeat (3) @(negedge clk);
        check("R12 all responses seen", exp_q.size(), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule